// File: doc/BRIEF.md
# DC-Balance Frame Encoder

This block turns one lane's 7-bit parallel words into a serial bit stream, one bit per clock. In balanced mode every frame is 9 bits long: the 7 data bits, sent either as written or bit-inverted, followed by a pair of complementary flag bits that tell the receiver which choice was made. The choice depends on the sign of the running ones-minus-zeros count of the line, so that the line never drifts far from an equal number of ones and zeros. This keeps an AC-coupled link free of baseline wander.

Framing runs without a gap. A word is captured into a holding register by a load strobe, and each frame boundary takes whatever word that register holds at that moment. If no new word has been loaded, the last word is sent again. The balance-enable input is sampled at each frame boundary. When it is low, the next frame is a plain 7-bit frame: no inversion, no flags, and no running count. The running count is brought out so that a checker can observe the line balance directly.

Top module: `dcb_frame_encoder`

## Requirements
- R1: While reset is asserted, `ser_bit` is 0, `frame_start` is 0 and `disparity` is 0.
- R2: A balanced frame is 9 clock cycles long. The 7 word bits go out most significant bit first, then the two flag bits. `frame_start` is high during the first bit of every frame and low on every other bit.
- R3: The flag pair is sent as 1 then 0 when the word went out true, and as 0 then 1 when it went out inverted. So the last two bits of a balanced frame always differ.
- R4: The word is inverted only when the running count at the frame boundary is nonzero and has the same sign as the word's own ones-minus-zeros count. A running count of zero always means the word is sent true.
- R5: In balanced mode, `disparity` shows the signed sum of +1 for each 1 bit and -1 for each 0 bit sent so far, not including the bit on the line now. The count starts from reset, or from the last plain frame. The flag pair adds zero to it.
- R6: While a balanced frame is on the line, `disparity` stays within -10 to +10. An all-ones word repeated, followed by a word with three leading ones and four zeros, reaches exactly +10.
- R7: With balance disabled, a frame is 7 bits of the word sent true, with no flag bits. `disparity` reads 0 for the whole frame.
- R8: Each frame carries the word that was last loaded before its boundary edge. With no new load, the previous word is sent again.
- R9: The balance-enable input is sampled only at frame boundaries. Changing it in the middle of a frame does not change that frame's length, flags or count.
- R10: At the first bit of every balanced frame, `disparity` lies within -7 to +7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_in | input | DATA_W | Parallel word to send |
| word_load | input | 1 | Captures `word_in` into the holding register |
| bal_en | input | 1 | 1 = balanced 9-bit frames, 0 = plain 7-bit frames |
| ser_bit | output | 1 | Serial line bit |
| frame_start | output | 1 | High on the first bit of each frame |
| disparity | output | SUM_W (signed) | Running ones-minus-zeros count before the current bit |

## Verification
The bound checker watches the following on every cycle: the ±10 bound on the running count, the tighter ±7 bound at frame starts, the count being held at zero through plain frames, each single-bit step of the count, and the complementary flag pair at the end of each balanced frame. The inversion decision, the bit order, the reuse of the held word and the immunity to a mid-frame mode change can be shown only by the bench. Its scoreboard predicts every bit, start marker and count value from its own model of the rule. Only the bench's chosen word sequence can show that the +10 extreme is actually reached.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  // Flag pair appended after the data bits (first-sent bit is the MSB).
  localparam logic [1:0] FLAG_TRUE = 2'b10;
  localparam logic [1:0] FLAG_INV  = 2'b01;

  // Ones-minus-zeros count of the low n bits of a vector.
  function automatic int bit_balance(input logic [31:0] bits, input int n);
    int s;
    s = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) s += bits[i] ? 1 : -1;
    end
    return s;
  endfunction

  // Inversion rule: running count and word count nonzero with equal sign.
  function automatic logic pick_invert(input int run_sum, input int word_sum);
    return (run_sum > 0 && word_sum > 0) || (run_sum < 0 && word_sum < 0);
  endfunction

endpackage

// File: rtl/dcb_word_coder.sv
module dcb_word_coder #(
  parameter int DATA_W = 7,
  parameter int SUM_W  = 6
) (
  input  logic [DATA_W-1:0]       word,
  input  logic signed [SUM_W-1:0] run_sum,
  input  logic                    bal,
  output logic [DATA_W+1:0]       frame
);
  import dcb_pkg::*;

  int   word_sum;
  logic invert;

  always_comb begin
    word_sum = bit_balance(32'(word), DATA_W);
    invert   = bal && pick_invert(int'(run_sum), word_sum);
    if (invert)   frame = {~word, FLAG_INV};
    else if (bal) frame = {word, FLAG_TRUE};
    else          frame = {word, 2'b00};
  end

endmodule

// File: rtl/dcb_frame_shifter.sv
module dcb_frame_shifter #(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W+1:0] frame,
  input  logic              bal_en,
  output logic              ser_bit,
  output logic              frame_start,
  output logic              boundary,
  output logic              live,
  output logic              frame_bal
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sr_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   last_idx;
  logic               live_q;
  logic               bal_q;

  assign last_idx = bal_q ? IDX_W'(FRAME_W - 1) : IDX_W'(DATA_W - 1);
  assign boundary = !live_q || (idx_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      idx_q  <= '0;
      live_q <= 1'b0;
      bal_q  <= 1'b1;
    end else if (boundary) begin
      sr_q   <= frame;
      idx_q  <= '0;
      live_q <= 1'b1;
      bal_q  <= bal_en;
    end else begin
      sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign ser_bit     = sr_q[FRAME_W-1];
  assign frame_start = live_q && (idx_q == '0);
  assign live        = live_q;
  assign frame_bal   = bal_q;

endmodule

// File: rtl/dcb_disparity_tracker.sv
module dcb_disparity_tracker #(
  parameter int SUM_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_bit,
  input  logic                    live,
  input  logic                    frame_bal,
  input  logic                    boundary,
  input  logic                    next_bal,
  output logic signed [SUM_W-1:0] sum_q,
  output logic signed [SUM_W-1:0] boundary_sum
);
  logic signed [SUM_W-1:0] step;

  always_comb begin
    if (live && frame_bal) step = ser_bit ? SUM_W'(1) : SUM_W'(-1);
    else                   step = '0;
    boundary_sum = sum_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sum_q <= '0;
    else if (boundary) sum_q <= next_bal ? boundary_sum : '0;
    else               sum_q <= frame_bal ? boundary_sum : '0;
  end

endmodule

// File: rtl/dcb_frame_encoder.sv
module dcb_frame_encoder #(
  parameter int DATA_W = 7,
  parameter int SUM_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       word_in,
  input  logic                    word_load,
  input  logic                    bal_en,
  output logic                    ser_bit,
  output logic                    frame_start,
  output logic signed [SUM_W-1:0] disparity
);
  logic [DATA_W-1:0]       hold_q;
  logic [DATA_W+1:0]       next_frame;
  logic                    boundary;
  logic                    live;
  logic                    frame_bal;
  logic signed [SUM_W-1:0] boundary_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= '0;
    else if (word_load) hold_q <= word_in;
  end

  dcb_word_coder #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_coder (
    .word    (hold_q),
    .run_sum (boundary_sum),
    .bal     (bal_en),
    .frame   (next_frame)
  );

  dcb_frame_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame       (next_frame),
    .bal_en      (bal_en),
    .ser_bit     (ser_bit),
    .frame_start (frame_start),
    .boundary    (boundary),
    .live        (live),
    .frame_bal   (frame_bal)
  );

  dcb_disparity_tracker #(.SUM_W(SUM_W)) u_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_bit      (ser_bit),
    .live         (live),
    .frame_bal    (frame_bal),
    .boundary     (boundary),
    .next_bal     (bal_en),
    .sum_q        (disparity),
    .boundary_sum (boundary_sum)
  );

endmodule

// File: rtl/dcb_frame_encoder_chk.sv
module dcb_frame_encoder_chk #(
  parameter int SUM_W      = 6,
  parameter int DSV_MAX    = 10,
  parameter int WORD_BOUND = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ser_bit,
  input logic                    frame_start,
  input logic signed [SUM_W-1:0] disparity,
  input logic                    boundary,
  input logic                    live,
  input logic                    frame_bal
);

  // R6
  dsv_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bal |-> (disparity <= DSV_MAX && disparity >= -DSV_MAX));

  // R10
  start_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frame_bal) |-> (disparity <= WORD_BOUND && disparity >= -WORD_BOUND));

  // R7
  plain_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_bal |-> (disparity == 0));

  // R2
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R3
  flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && frame_bal && boundary) |-> (ser_bit != $past(ser_bit)));

  // R5
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && frame_bal && !boundary && ser_bit) |=> (disparity == $past(disparity) + 1));

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && frame_bal && !boundary && !ser_bit) |=> (disparity == $past(disparity) - 1));

endmodule

bind dcb_frame_encoder dcb_frame_encoder_chk #(.SUM_W(SUM_W)) u_chk (.*);

// File: tb/test_dcb_frame_encoder.sv
module test_dcb_frame_encoder;
  localparam int DATA_W = 7;
  localparam int SUM_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] word_in = '0;
  logic              word_load = 1'b0;
  logic              bal_en = 1'b1;
  logic              ser_bit;
  logic              frame_start;
  logic signed [SUM_W-1:0] disparity;

  always #4 clk = ~clk;

  dcb_frame_encoder #(.DATA_W(DATA_W), .SUM_W(SUM_W)) i_dcb_frame_encoder (.*);

  typedef struct {
    logic  b;
    logic  fs;
    int    disp;
    string req;
  } exp_t;

  exp_t        sb[$];
  int          vectors = 0;
  int          misses = 0;
  int          m_sum = 0;
  logic [6:0]  m_hold = '0;
  int          peak = 0;
  logic        started = 1'b0;
  logic        done = 1'b0;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  // Model: predict one whole frame and queue its bits.
  task automatic push_frame(input logic [6:0] w, input logic b);
    int         ones;
    int         d;
    int         n;
    logic       inv;
    logic [8:0] bits;
    ones = 0;
    for (int i = 0; i < 7; i++) ones += w[i] ? 1 : 0;
    d   = 2 * ones - 7;
    inv = b && (m_sum * d > 0);                 // R4
    if (!b) begin bits = {w, 2'b00}; n = 7; m_sum = 0; end   // R7
    else if (inv) begin bits = {~w, 2'b01}; n = 9; end        // R3
    else begin bits = {w, 2'b10}; n = 9; end
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.b    = bits[8-i];
      e.fs   = (i == 0);
      e.disp = b ? m_sum : 0;
      if (!b)         e.req = "R7";
      else if (i == 0) e.req = "R2 R8 R5";
      else if (i >= 7) e.req = "R3 R5";
      else             e.req = "R4 R5";
      sb.push_back(e);
      if (b) m_sum += bits[8-i] ? 1 : -1;
    end
  endtask

  // Driver: one frame ahead; toggles bal_en mid-frame to exercise R9.
  task automatic run_step(input logic [6:0] w, input logic b, input logic ld);
    do @(negedge clk); while (frame_start !== 1'b1);
    word_in   = w;
    word_load = ld;
    bal_en    = b;
    if (ld) m_hold = w;
    push_frame(m_hold, b);
    @(negedge clk);
    word_load = 1'b0;
    bal_en    = ~b;
    @(negedge clk);
    @(negedge clk);
    bal_en    = b;
  endtask

  // Monitor: pop and compare each bit as it appears.
  always @(negedge clk) begin
    exp_t e;
    int   a;
    if (rst_n && frame_start) started = 1'b1;
    if (rst_n && started && sb.size() > 0) begin
      e = sb.pop_front();
      vectors++;
      if (ser_bit !== e.b || frame_start !== e.fs || int'(disparity) != e.disp) begin
        misses++;
        $display("FAIL %s: bit/start/sum actual %0b/%0b/%0d expected %0b/%0b/%0d",
                 e.req, ser_bit, frame_start, disparity, e.b, e.fs, e.disp);
      end
      a = int'(disparity);
      if (a < 0) a = -a;
      if (a > peak) peak = a;
    end
  end

  initial begin
    push_frame(7'h00, 1'b1);   // first frame after reset sends the reset hold value
    repeat (3) @(negedge clk);
    // R1 reset state
    vectors++;
    if (ser_bit !== 1'b0) begin misses++; $display("FAIL R1: ser_bit actual %0b expected 0", ser_bit); end
    vectors++;
    if (frame_start !== 1'b0) begin misses++; $display("FAIL R1: frame_start actual %0b expected 0", frame_start); end
    vectors++;
    if (disparity !== '0) begin misses++; $display("FAIL R1: disparity actual %0d expected 0", disparity); end
    rst_n = 1'b1;

    run_step(7'h7F, 1'b1, 1'b1);          // count -7 -> 0
    run_step(7'h00, 1'b1, 1'b0);          // R8 repeat all ones: 0 -> 7
    run_step(7'h70, 1'b1, 1'b1);          // R6 peak of +10 inside frame
    run_step(7'h7F, 1'b1, 1'b1);          // R4 positive count: inverted
    repeat (3) run_step(7'h00, 1'b1, 1'b0);
    run_step(7'h00, 1'b1, 1'b1);
    run_step(7'h00, 1'b1, 1'b0);
    run_step(7'h55, 1'b0, 1'b1);          // R7 plain frames
    run_step(7'h2A, 1'b0, 1'b1);
    run_step(7'h00, 1'b0, 1'b0);
    run_step(7'h7F, 1'b1, 1'b1);          // back to balanced from count 0
    run_step(7'h01, 1'b1, 1'b1);
    for (int k = 0; k < 40; k++) begin
      run_step(7'($urandom), ($urandom % 5) != 0, ($urandom % 4) != 0);
    end

    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    // R6 extreme reached and not exceeded
    vectors++;
    if (peak != 10) begin
      misses++;
      $display("FAIL R6: peak |disparity| actual %0d expected 10", peak);
    end
    finish_run();
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      misses++;
      $display("FAIL R2: run hung, queue depth actual %0d expected 0", sb.size());
      finish_run();
    end
  end

endmodule